// File: doc/BRIEF.md
# Integer ALU with Selective Overflow

This is a purely combinational 32-bit integer arithmetic and logic unit for the execute stage of a load-store RISC core. The decode stage hands it two register operands, a 16-bit immediate, a 5-bit constant shift amount, a 4-bit operation code and a flag saying whether the instruction is of the immediate kind. From the same inputs it returns a result word and an overflow flag. The core uses that flag to raise an arithmetic exception.

Overflow is reported only for the trapping (signed) forms of add and subtract. Their non-trapping twins produce the same bits and never flag. When the immediate flag is set, the immediate is widened before use. Logical operations zero-fill it. Add, subtract and compare sign-fill it, and this includes the non-trapping add. For shifts, the same flag chooses between the constant amount in the instruction and a variable amount taken from a register.

Top module: `alu_top`

## Requirements
- R1: Operation codes are 0 add, 1 add-nowrap-free (non-trapping add), 2 subtract, 3 non-trapping subtract, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 signed less-than, 9 unsigned less-than, 10 shift left logical, 11 shift right logical, 12 shift right arithmetic, 13 load upper. Add and subtract results wrap modulo 2^32.
- R2: Codes 0 and 2 raise `overflow` when the two's-complement result does not fit in 32 bits. This applies to the register form and the immediate form. The wrapped result is still driven on `result`.
- R3: `overflow` is 0 for every code other than 0 and 2, whatever the operands.
- R4: With `useImm`=1, codes 0 to 9 take the extended immediate as second operand. It is zero-extended for codes 4 to 7 and sign-extended for codes 0 to 3, 8 and 9.
- R5: Codes 4 to 7 give bitwise AND, OR, XOR and the inverse of the OR.
- R6: Codes 8 and 9 return 1 when `opA` is below the second operand and 0 otherwise. Code 8 compares as two's complement and code 9 as unsigned.
- R7: Codes 10 to 12 shift `opA`. The amount is `shamt` when `useImm`=1 and `opB[4:0]` when `useImm`=0; the upper bits of `opB` are ignored. Arithmetic right shift fills with `opA[31]`.
- R8: Code 13 returns `imm` in bits 31:16 and zeros in bits 15:0.
- R9: Codes 14 and 15 return 0 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First register operand; the value shifted |
| opB | input | 32 | Second register operand; variable shift amount in bits 4:0 |
| imm | input | 16 | Instruction immediate |
| shamt | input | 5 | Constant shift amount from the instruction |
| op | input | 4 | Operation code (R1) |
| useImm | input | 1 | Immediate-kind instruction |
| result | output | 32 | Result word |
| overflow | output | 1 | Signed add/subtract overflow |

## Verification
The immediate checks assume that all inputs are settled, known values whenever the combinational logic is evaluated. No X or Z may appear on `op` or `useImm`. The bench drives every input together from one task just after a rising clock edge and holds it for the whole cycle. It compares outputs only at the following falling edge, so the checks always see one consistent operand set.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;
  localparam int SH_W   = 5;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OP_ADD  = 4'd0;
  localparam logic [OP_W-1:0] OP_ADDU = 4'd1;
  localparam logic [OP_W-1:0] OP_SUB  = 4'd2;
  localparam logic [OP_W-1:0] OP_SUBU = 4'd3;
  localparam logic [OP_W-1:0] OP_AND  = 4'd4;
  localparam logic [OP_W-1:0] OP_OR   = 4'd5;
  localparam logic [OP_W-1:0] OP_XOR  = 4'd6;
  localparam logic [OP_W-1:0] OP_NOR  = 4'd7;
  localparam logic [OP_W-1:0] OP_SLT  = 4'd8;
  localparam logic [OP_W-1:0] OP_SLTU = 4'd9;
  localparam logic [OP_W-1:0] OP_SLL  = 4'd10;
  localparam logic [OP_W-1:0] OP_SRL  = 4'd11;
  localparam logic [OP_W-1:0] OP_SRA  = 4'd12;
  localparam logic [OP_W-1:0] OP_LUI  = 4'd13;

  typedef enum logic [2:0] {
    RES_ARITH, RES_LOGIC, RES_CMP, RES_SHIFT, RES_UPPER, RES_NONE
  } resSel_e;

  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logicFn_e;

  typedef enum logic [1:0] {SH_LL, SH_RL, SH_RA} shiftFn_e;

  typedef struct packed {
    logic     bFromImm;
    logic     immSext;
    logic     subtract;
    logic     ovfEnable;
    logic     cmpUnsigned;
    logic     shiftConst;
    resSel_e  resSel;
    logicFn_e logicFn;
    shiftFn_e shiftFn;
  } aluStrobes_t;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic [OPW-1:0] opCode,
  input  logic           useImm,
  output aluStrobes_t    strobes
);
  always_comb begin
    strobes = '{bFromImm: 1'b0, immSext: 1'b0, subtract: 1'b0, ovfEnable: 1'b0,
                cmpUnsigned: 1'b0, shiftConst: 1'b0, resSel: RES_NONE,
                logicFn: LG_AND, shiftFn: SH_LL};
    case (opCode)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: begin
        strobes.bFromImm  = useImm;
        strobes.immSext   = 1'b1;
        strobes.subtract  = (opCode == OP_SUB) || (opCode == OP_SUBU);
        strobes.ovfEnable = (opCode == OP_ADD) || (opCode == OP_SUB);
        strobes.resSel    = RES_ARITH;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOR: begin
        strobes.bFromImm = useImm;
        strobes.immSext  = 1'b0;
        strobes.resSel   = RES_LOGIC;
        case (opCode)
          OP_AND:  strobes.logicFn = LG_AND;
          OP_OR:   strobes.logicFn = LG_OR;
          OP_XOR:  strobes.logicFn = LG_XOR;
          default: strobes.logicFn = LG_NOR;
        endcase
      end
      OP_SLT, OP_SLTU: begin
        strobes.bFromImm    = useImm;
        strobes.immSext     = 1'b1;
        strobes.cmpUnsigned = (opCode == OP_SLTU);
        strobes.resSel      = RES_CMP;
      end
      OP_SLL, OP_SRL, OP_SRA: begin
        strobes.shiftConst = useImm;
        strobes.resSel     = RES_SHIFT;
        case (opCode)
          OP_SLL:  strobes.shiftFn = SH_LL;
          OP_SRL:  strobes.shiftFn = SH_RL;
          default: strobes.shiftFn = SH_RA;
        endcase
      end
      OP_LUI: strobes.resSel = RES_UPPER;
      default: strobes.resSel = RES_NONE;
    endcase
  end

  always_comb begin
    // R4
    imm_ext_kind_chk: assert (!(strobes.resSel == RES_LOGIC) || !strobes.immSext)
      else $error("logical op requested sign extension");
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int SHW = SH_W
) (
  input  logic [W-1:0]   value,
  input  logic [SHW-1:0] amount,
  input  shiftFn_e       fn,
  output logic [W-1:0]   shifted
);
  logic [W-1:0] leftStage  [0:SHW];
  logic [W-1:0] rightStage [0:SHW];
  logic         fillBit;

  assign fillBit       = (fn == SH_RA) && value[W-1];
  assign leftStage[0]  = value;
  assign rightStage[0] = value;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign leftStage[i+1]  = amount[i] ? {leftStage[i][W-1-STEP:0], {STEP{1'b0}}}
                                       : leftStage[i];
    assign rightStage[i+1] = amount[i] ? {{STEP{fillBit}}, rightStage[i][W-1:STEP]}
                                       : rightStage[i];
  end

  assign shifted = (fn == SH_LL) ? leftStage[SHW] : rightStage[SHW];

  always_comb begin
    // R7
    sra_sign_chk: assert (!(fn == SH_RA) || (shifted[W-1] == value[W-1]))
      else $error("arithmetic shift lost sign");
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int IW  = IMM_W,
  parameter int SHW = SH_W
) (
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [IW-1:0]  imm,
  input  logic [SHW-1:0] shamt,
  input  aluStrobes_t    strobes,
  output logic [W-1:0]   result,
  output logic           overflow
);
  localparam int PAD_W = W - IW;

  logic [W-1:0]   immExt, bOperand, bAdj, sum, logicRes, shiftRes, upperRes;
  logic [SHW-1:0] shiftAmt;
  logic           ovfRaw, lessThan;

  assign immExt   = strobes.immSext ? {{PAD_W{imm[IW-1]}}, imm} : {{PAD_W{1'b0}}, imm};
  assign bOperand = strobes.bFromImm ? immExt : opB;
  assign bAdj     = strobes.subtract ? ~bOperand : bOperand;
  assign sum      = opA + bAdj + {{(W-1){1'b0}}, strobes.subtract};
  assign ovfRaw   = (opA[W-1] == bAdj[W-1]) && (sum[W-1] != opA[W-1]);
  assign overflow = strobes.ovfEnable && ovfRaw && (strobes.resSel == RES_ARITH);

  assign lessThan = strobes.cmpUnsigned ? (opA < bOperand)
                                        : ($signed(opA) < $signed(bOperand));

  always_comb begin
    case (strobes.logicFn)
      LG_AND:  logicRes = opA & bOperand;
      LG_OR:   logicRes = opA | bOperand;
      LG_XOR:  logicRes = opA ^ bOperand;
      default: logicRes = ~(opA | bOperand);
    endcase
  end

  assign shiftAmt = strobes.shiftConst ? shamt : opB[SHW-1:0];

  alu_shifter #(.W(W), .SHW(SHW)) u_shift (
    .value  (opA),
    .amount (shiftAmt),
    .fn     (strobes.shiftFn),
    .shifted(shiftRes)
  );

  assign upperRes = {imm, {PAD_W{1'b0}}};

  always_comb begin
    case (strobes.resSel)
      RES_ARITH: result = sum;
      RES_LOGIC: result = logicRes;
      RES_CMP:   result = {{(W-1){1'b0}}, lessThan};
      RES_SHIFT: result = shiftRes;
      RES_UPPER: result = upperRes;
      default:   result = '0;
    endcase
  end

  always_comb begin
    // R8
    lui_low_chk: assert (!(strobes.resSel == RES_UPPER) || (result[PAD_W-1:0] == '0))
      else $error("upper-immediate low half not clear");
    // R6
    slt_bool_chk: assert (!(strobes.resSel == RES_CMP) || (result[W-1:1] == '0))
      else $error("compare result not 0/1");
    // R2
    ovf_sign_chk: assert (!overflow || (result[W-1] != opA[W-1]))
      else $error("overflow without sign change");
    // R5
    nor_chk: assert (!(strobes.resSel == RES_LOGIC && strobes.logicFn == LG_NOR)
                     || ((result & (opA | bOperand)) == '0))
      else $error("NOR overlaps OR");
  end
endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int W   = DATA_W,
  parameter int IW  = IMM_W,
  parameter int SHW = SH_W,
  parameter int OPW = OP_W
) (
  input  logic [W-1:0]   opA,
  input  logic [W-1:0]   opB,
  input  logic [IW-1:0]  imm,
  input  logic [SHW-1:0] shamt,
  input  logic [OPW-1:0] op,
  input  logic           useImm,
  output logic [W-1:0]   result,
  output logic           overflow
);
  aluStrobes_t strobes;

  alu_ctrl #(.OPW(OPW)) u_ctrl (
    .opCode (op),
    .useImm (useImm),
    .strobes(strobes)
  );

  alu_datapath #(.W(W), .IW(IW), .SHW(SHW)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .imm     (imm),
    .shamt   (shamt),
    .strobes (strobes),
    .result  (result),
    .overflow(overflow)
  );

  always_comb begin
    // R3
    no_overflow_chk: assert (!overflow || op == OP_ADD || op == OP_SUB)
      else $error("overflow on non-trapping op");
    // R9
    unused_op_chk: assert (op < 4'd14 || (result == '0 && !overflow))
      else $error("unused code produced output");
  end
endmodule

// File: tb/sim_alu_top.sv
module sim_alu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0, opB = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  op = '0;
  logic        useImm = 1'b0;
  logic [31:0] result;
  logic        overflow;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    string       tag;
  } expItem_t;
  expItem_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_top u0 (
    .opA(opA), .opB(opB), .imm(imm), .shamt(shamt),
    .op(op), .useImm(useImm), .result(result), .overflow(overflow)
  );

  task automatic drive(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input logic ui,
                       input logic [31:0] er, input logic eo, input string tag);
    @(posedge clk);
    op = o; opA = a; opB = b; imm = im; shamt = sh; useImm = ui;
    sb.push_back('{er, eo, tag});
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      testCnt++;
      if (result !== it.res || overflow !== it.ovf) begin
        failCnt++;
        $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                 it.tag, result, overflow, it.res, it.ovf);
      end
    end
  end

  function automatic string tagFor(input logic [3:0] o);
    case (o)
      4'd0, 4'd2:        return "R2 model";
      4'd1, 4'd3:        return "R3 model";
      4'd4, 4'd5, 4'd6, 4'd7: return "R5 model";
      4'd8, 4'd9:        return "R6 model";
      4'd10, 4'd11, 4'd12: return "R7 model";
      4'd13:             return "R8 model";
      default:           return "R9 model";
    endcase
  endfunction

  function automatic void model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                                input logic [15:0] im, input logic [4:0] sh, input logic ui,
                                output logic [31:0] r, output logic ov);
    logic [31:0] bs, bz, bArith, bLogic;
    longint      s;
    int          amt;
    bs = {{16{im[15]}}, im};
    bz = {16'h0000, im};
    bArith = ui ? bs : b;
    bLogic = ui ? bz : b;
    amt = ui ? int'(sh) : int'(b[4:0]);
    r = '0; ov = 1'b0;
    case (o)
      4'd0, 4'd1: begin
        r = a + bArith;
        s = longint'($signed(a)) + longint'($signed(bArith));
        ov = (o == 4'd0) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
      end
      4'd2, 4'd3: begin
        r = a - bArith;
        s = longint'($signed(a)) - longint'($signed(bArith));
        ov = (o == 4'd2) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
      end
      4'd4:  r = a & bLogic;
      4'd5:  r = a | bLogic;
      4'd6:  r = a ^ bLogic;
      4'd7:  r = ~(a | bLogic);
      4'd8:  r = ($signed(a) < $signed(bArith)) ? 32'd1 : 32'd0;
      4'd9:  r = (a < bArith) ? 32'd1 : 32'd0;
      4'd10: r = a << amt;
      4'd11: r = a >> amt;
      4'd12: r = $signed(a) >>> amt;
      4'd13: r = {im, 16'h0000};
      default: r = '0;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog (all requirements): result=%h expected completion", result);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] er, ra, rb;
    logic        eo;
    logic [15:0] ri;
    logic [4:0]  rs;
    logic        ru;
    // reset state: all-zero inputs give zero, no overflow (R1)
    drive(4'd0, 32'h0, 32'h0, 16'h0, 5'd0, 1'b0, 32'h0, 1'b0, "R1 reset");
    @(posedge clk); rst = 1'b0;
    // R1 wrap
    drive(4'd1, 32'hFFFFFFFF, 32'h2, 16'h0, 5'd0, 1'b0, 32'h00000001, 1'b0, "R1 wrap addu");
    // R2 signed overflow, result still given
    drive(4'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 1'b0, 32'h80000000, 1'b1, "R2 add ovf");
    drive(4'd2, 32'h80000000, 32'h1, 16'h0, 5'd0, 1'b0, 32'h7FFFFFFF, 1'b1, "R2 sub ovf");
    drive(4'd2, 32'h00000000, 32'h80000000, 16'h0, 5'd0, 1'b0, 32'h80000000, 1'b1, "R2 sub min");
    drive(4'd0, 32'h7FFFFFFF, 32'h0, 16'h0001, 5'd0, 1'b1, 32'h80000000, 1'b1, "R2 addi ovf");
    drive(4'd0, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 1'b0, 32'h00000000, 1'b0, "R2 add no ovf");
    // R3 non-trapping forms
    drive(4'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 5'd0, 1'b0, 32'h80000000, 1'b0, "R3 addu");
    drive(4'd3, 32'h80000000, 32'h1, 16'h0, 5'd0, 1'b0, 32'h7FFFFFFF, 1'b0, "R3 subu");
    // R4 immediate extension
    drive(4'd0, 32'h5, 32'h0, 16'hFFFF, 5'd0, 1'b1, 32'h00000004, 1'b0, "R4 addi sext");
    drive(4'd1, 32'h0, 32'hFFFFFFFF, 16'h8000, 5'd0, 1'b1, 32'hFFFF8000, 1'b0, "R4 addiu sext");
    drive(4'd5, 32'h0, 32'hFFFFFFFF, 16'hFFFF, 5'd0, 1'b1, 32'h0000FFFF, 1'b0, "R4 ori zext");
    drive(4'd4, 32'hFFFFFFFF, 32'h0, 16'h8000, 5'd0, 1'b1, 32'h00008000, 1'b0, "R4 andi zext");
    // R5 logic
    drive(4'd7, 32'hF0F0F0F0, 32'h0F0F0000, 16'h0, 5'd0, 1'b0, 32'h00000F0F, 1'b0, "R5 nor");
    drive(4'd6, 32'hFF00FF00, 32'h0FF00FF0, 16'h0, 5'd0, 1'b0, 32'hF0F0F0F0, 1'b0, "R5 xor");
    // R6 compares
    drive(4'd8, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 1'b0, 32'h1, 1'b0, "R6 slt");
    drive(4'd9, 32'hFFFFFFFF, 32'h1, 16'h0, 5'd0, 1'b0, 32'h0, 1'b0, "R6 sltu");
    drive(4'd8, 32'h0, 32'h0, 16'hFFFF, 5'd0, 1'b1, 32'h0, 1'b0, "R6 slti");
    drive(4'd9, 32'h0, 32'h0, 16'hFFFF, 5'd0, 1'b1, 32'h1, 1'b0, "R6 sltiu");
    // R7 shifts
    drive(4'd10, 32'h1, 32'h0, 16'h0, 5'd31, 1'b1, 32'h80000000, 1'b0, "R7 sll const");
    drive(4'd12, 32'h80000000, 32'hFFFFFFE4, 16'h0, 5'd0, 1'b0, 32'hF8000000, 1'b0, "R7 sra var");
    drive(4'd11, 32'h80000000, 32'hFFFFFFE4, 16'h0, 5'd9, 1'b0, 32'h08000000, 1'b0, "R7 srl var");
    drive(4'd12, 32'h80000001, 32'h0000001F, 16'h0, 5'd0, 1'b1, 32'h80000001, 1'b0, "R7 sra zero");
    // R8 upper immediate
    drive(4'd13, 32'h12345678, 32'hFFFFFFFF, 16'hABCD, 5'd3, 1'b1, 32'hABCD0000, 1'b0, "R8 lui");
    // R9 unused codes
    drive(4'd14, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 5'd4, 1'b0, 32'h0, 1'b0, "R9 code14");
    drive(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd4, 1'b1, 32'h0, 1'b0, "R9 code15");
    // model-driven sweep over every code
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 24; n++) begin
        ra = $urandom; rb = $urandom; ri = 16'($urandom); rs = 5'($urandom); ru = 1'($urandom);
        if (n < 4) begin
          ra = (n[0]) ? 32'h7FFFFFFF : 32'h80000000;
          rb = (n[1]) ? 32'h80000000 : 32'h7FFFFFFF;
        end
        model(4'(o), ra, rb, ri, rs, ru, er, eo);
        drive(4'(o), ra, rb, ri, rs, ru, er, eo, tagFor(4'(o)));
      end
    end
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule